// File: doc/BRIEF.md
# Preemptive Channel Arbiter

This block chooses which of sixteen transfer channels the shared transfer engine serves next. Every channel carries a 4-bit priority, where 0 ranks lowest and 15 ranks highest, and an enable bit that lets a higher-ranked requester take its place. A mode input selects between two schemes. In fixed-priority mode the block always picks the highest-ranked requester. In round-robin mode it rotates through the requesting channels. The transfer engine reports two kinds of event back to the arbiter. A sequence-done pulse marks the end of one read/write sequence on the active channel. A loop-done pulse marks the end of that channel's minor loop, at which point the channel gives the engine up.

Preemption goes one level deep only. An enabled channel can be suspended at a sequence boundary in favour of a higher-ranked requester. The suspended channel is recorded and comes back on the same edge that the preempting channel reports its loop done. A preempting channel can never be preempted itself. If any two priorities are equal, a configuration-error flag rises and no new grant or preemption is made. A readback port returns the priority that is currently configured for a selected channel.

Top module: `chan_arbiter`

## Requirements
- R1: After reset, act_valid is 0 and susp_valid is 0.
- R2: In fixed mode (rr_mode=0) with no active channel and cfg_err=0, the arbiter grants on the next clock edge. The grant goes to the requesting channel with the numerically largest priority, where channel i's priority is prio_cfg[4i+3:4i] and 0 is the lowest.
- R3: cfg_err is 1 combinationally whenever two channels hold the same priority value, and 0 when all sixteen values are distinct.
- R4: While cfg_err is 1, no new grant is issued and no preemption happens.
- R5: In fixed mode a preemption happens on the edge that samples seq_done=1, provided the active channel has its preempt_en bit set, no channel is suspended, and another requester has a strictly higher priority. On that edge the requester becomes active and the old channel is recorded in susp_idx with susp_valid=1. Without seq_done the active index does not change.
- R6: An active channel whose preempt_en bit is 0 is never suspended.
- R7: On the edge that samples loop_done=1 while a channel is suspended, the suspended channel becomes active again and susp_valid clears.
- R8: A restored channel keeps the engine until it reports sequence done. At that sequence-done edge it is suspended again if a higher-priority request is pending.
- R9: While a channel is suspended, the active preempting channel is not preempted, even by a higher-priority requester.
- R10: In round-robin mode (rr_mode=1) no preemption occurs. Each grant goes to the first requesting index after the last granted index, counting upward and wrapping from 15 to 0. After reset the search begins at index 0.
- R11: loop_done with no suspended channel clears act_valid on that edge. A pending request is then granted on the following edge.
- R12: prio_rd returns the configured priority of the channel selected by prio_rd_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rr_mode | input | 1 | 1 selects round-robin mode, 0 selects fixed priority |
| prio_cfg | input | 64 | Sixteen 4-bit priorities; channel i uses bits 4i+3:4i |
| preempt_en | input | 16 | Per-channel enable for being preempted |
| req | input | 16 | Per-channel service requests |
| seq_done | input | 1 | Pulse: the active channel finished one read/write sequence |
| loop_done | input | 1 | Pulse: the active channel finished its minor loop |
| prio_rd_sel | input | 4 | Channel whose priority is read back |
| prio_rd | output | 4 | Configured priority of the selected channel |
| act_valid | output | 1 | A channel currently owns the engine |
| act_idx | output | 4 | Index of the active channel |
| susp_valid | output | 1 | A preempted channel is waiting to be restored |
| susp_idx | output | 4 | Index of the preempted channel |
| cfg_err | output | 1 | Duplicate priority values detected |

## Verification
The priority configuration used is the permutation (7i+3) mod 16. Under it, channel index order and priority order disagree everywhere, so a winner picked by index instead of by value stands out. A table of request masks runs from single requesters through pairs to all sixteen, which tells a true maximum apart from first-set or last-set selection. Directed sequences then walk through preemption, a blocked nested preemption, restore and re-preemption, a disabled preemption bit, and a duplicate priority. A round-robin pass uses a request set that wraps past index 15, which tells rotation from the last grant apart from a plain index scan.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Action chosen for the coming clock edge
  typedef enum logic [2:0] {
    EV_HOLD    = 3'd0,
    EV_GRANT   = 3'd1,
    EV_PREEMPT = 3'd2,
    EV_RESTORE = 3'd3,
    EV_RELEASE = 3'd4
  } arb_ev_e;
endpackage

// File: rtl/prio_dup_detect.sv
module prio_dup_detect #(
  parameter int NCH = 16,
  parameter int PW  = 4
) (
  input  logic [NCH*PW-1:0] prio_flat,
  output logic              dup
);
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      for (int j = i + 1; j < NCH; j++) begin
        if (prio_flat[i*PW +: PW] == prio_flat[j*PW +: PW]) dup = 1'b1;
      end
    end
  end
endmodule

// File: rtl/prio_select.sv
module prio_select #(
  parameter int NCH  = 16,
  parameter int PW   = 4,
  parameter int IDXW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    req_i,
  input  logic [NCH*PW-1:0] prio_flat,
  output logic              win_valid,
  output logic [IDXW-1:0]   win_idx,
  output logic [PW-1:0]     win_prio
);
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '0;
    for (int i = 0; i < NCH; i++) begin
      if (req_i[i] && (!win_valid || prio_flat[i*PW +: PW] > win_prio)) begin
        win_valid = 1'b1;
        win_idx   = IDXW'(i);
        win_prio  = prio_flat[i*PW +: PW];
      end
    end
  end

  AST_WIN_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> req_i[win_idx]); // R2
  AST_WIN_WHEN_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i != '0) |-> win_valid); // R2
endmodule

// File: rtl/rr_select.sv
module rr_select #(
  parameter int NCH  = 16,
  parameter int IDXW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  req_i,
  input  logic [IDXW-1:0] last_idx,
  output logic            win_valid,
  output logic [IDXW-1:0] win_idx
);
  function automatic int step_from(input int base, input int k);
    return (base + k) % NCH;
  endfunction

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    for (int k = 1; k <= NCH; k++) begin
      if (!win_valid && req_i[step_from(int'(last_idx), k)]) begin
        win_valid = 1'b1;
        win_idx   = IDXW'(step_from(int'(last_idx), k));
      end
    end
  end

  AST_RR_WIN_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> req_i[win_idx]); // R10
endmodule

// File: rtl/chan_arbiter.sv
module chan_arbiter
  import arb_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int PW   = 4,
  parameter int IDXW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rr_mode,
  input  logic [NCH*PW-1:0] prio_cfg,
  input  logic [NCH-1:0]    preempt_en,
  input  logic [NCH-1:0]    req,
  input  logic              seq_done,
  input  logic              loop_done,
  input  logic [IDXW-1:0]   prio_rd_sel,
  output logic [PW-1:0]     prio_rd,
  output logic              act_valid,
  output logic [IDXW-1:0]   act_idx,
  output logic              susp_valid,
  output logic [IDXW-1:0]   susp_idx,
  output logic              cfg_err
);
  localparam logic [IDXW-1:0] LAST_RESET = IDXW'(NCH - 1);

  function automatic logic [PW-1:0] prio_of(input logic [NCH*PW-1:0] cfg,
                                            input logic [IDXW-1:0] idx);
    return cfg[int'(idx)*PW +: PW];
  endfunction

  logic [IDXW-1:0] last_idx;
  logic [NCH-1:0]  act_mask;
  logic [NCH-1:0]  req_other;
  logic            fx_valid, rr_valid, sel_valid;
  logic [IDXW-1:0] fx_idx, rr_idx, sel_idx;
  logic [PW-1:0]   fx_prio, act_prio;
  logic            grant_fire, preempt_fire, restore_fire, release_fire;
  arb_ev_e         ev;

  // Priority readback
  assign prio_rd = prio_of(prio_cfg, prio_rd_sel);

  prio_dup_detect #(.NCH(NCH), .PW(PW)) u_dup (
    .prio_flat (prio_cfg),
    .dup       (cfg_err)
  );

  // The active channel never competes against itself
  always_comb begin
    act_mask = '0;
    if (act_valid) act_mask[act_idx] = 1'b1;
  end
  assign req_other = req & ~act_mask;

  prio_select #(.NCH(NCH), .PW(PW), .IDXW(IDXW)) u_fx (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_other),
    .prio_flat (prio_cfg),
    .win_valid (fx_valid),
    .win_idx   (fx_idx),
    .win_prio  (fx_prio)
  );

  rr_select #(.NCH(NCH), .IDXW(IDXW)) u_rr (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_other),
    .last_idx  (last_idx),
    .win_valid (rr_valid),
    .win_idx   (rr_idx)
  );

  assign sel_valid = rr_mode ? rr_valid : fx_valid;
  assign sel_idx   = rr_mode ? rr_idx   : fx_idx;
  assign act_prio  = prio_of(prio_cfg, act_idx);

  // Named events
  assign grant_fire   = !act_valid && !cfg_err && sel_valid;
  assign restore_fire = act_valid && loop_done && susp_valid;
  assign release_fire = act_valid && loop_done && !susp_valid;
  assign preempt_fire = act_valid && seq_done && !loop_done && !rr_mode &&
                        !cfg_err && !susp_valid && preempt_en[act_idx] &&
                        fx_valid && (fx_prio > act_prio);

  always_comb begin
    if (grant_fire)        ev = EV_GRANT;
    else if (restore_fire) ev = EV_RESTORE;
    else if (release_fire) ev = EV_RELEASE;
    else if (preempt_fire) ev = EV_PREEMPT;
    else                   ev = EV_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_valid  <= 1'b0;
      act_idx    <= '0;
      susp_valid <= 1'b0;
      susp_idx   <= '0;
      last_idx   <= LAST_RESET;
    end else begin
      case (ev)
        EV_GRANT: begin
          act_valid <= 1'b1;
          act_idx   <= sel_idx;
          last_idx  <= sel_idx;
        end
        EV_PREEMPT: begin
          susp_valid <= 1'b1;
          susp_idx   <= act_idx;
          act_idx    <= fx_idx;
        end
        EV_RESTORE: begin
          act_idx    <= susp_idx;
          susp_valid <= 1'b0;
        end
        EV_RELEASE: act_valid <= 1'b0;
        default: ;
      endcase
    end
  end

  AST_ERR_BLOCKS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !act_valid) |=> !act_valid); // R4
  AST_PREEMPT_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !susp_valid && !preempt_en[act_idx]) |=> !susp_valid); // R6
  AST_RESTORE_SUSPENDED: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && loop_done && susp_valid) |=>
      (act_valid && !susp_valid && act_idx == $past(susp_idx))); // R7
  AST_INDEX_HELD_MIDSEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !seq_done && !loop_done) |=> (act_valid && $stable(act_idx))); // R8
  AST_NO_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_valid && !loop_done) |=> (susp_valid && $stable(susp_idx))); // R9
  AST_SUSP_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    susp_valid |-> (act_valid && act_idx != susp_idx)); // R9
  AST_RR_NO_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_mode && !susp_valid) |=> !susp_valid); // R10
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && loop_done && !susp_valid) |=> !act_valid); // R11
endmodule

// File: tb/tb_chan_arbiter.sv
module tb_chan_arbiter;
  localparam int NCH = 16;
  localparam int PW  = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            rr_mode;
  logic [NCH*PW-1:0] prio_cfg;
  logic [NCH-1:0]  preempt_en;
  logic [NCH-1:0]  req;
  logic            seq_done, loop_done;
  logic [3:0]      prio_rd_sel;
  logic [3:0]      prio_rd;
  logic            act_valid, susp_valid, cfg_err;
  logic [3:0]      act_idx, susp_idx;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  chan_arbiter dut (
    .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .prio_cfg(prio_cfg),
    .preempt_en(preempt_en), .req(req), .seq_done(seq_done),
    .loop_done(loop_done), .prio_rd_sel(prio_rd_sel), .prio_rd(prio_rd),
    .act_valid(act_valid), .act_idx(act_idx), .susp_valid(susp_valid),
    .susp_idx(susp_idx), .cfg_err(cfg_err)
  );

  // {request mask, expected winner} under priority (7i+3) mod 16
  localparam logic [19:0] FX_VECS [0:7] = '{
    {16'h0001, 4'd0},
    {16'h0003, 4'd1},
    {16'h8001, 4'd15},
    {16'h0810, 4'd4},
    {16'h2100, 4'd13},
    {16'h0A00, 4'd9},
    {16'hFFFF, 4'd4},
    {16'h00C0, 4'd6}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_seq();
    seq_done = 1'b1; step(); seq_done = 1'b0;
  endtask

  task automatic pulse_loop();
    loop_done = 1'b1; step(); loop_done = 1'b0;
  endtask

  task automatic load_unique();
    for (int i = 0; i < NCH; i++) prio_cfg[i*PW +: PW] = 4'((7*i + 3) % 16);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; step(); step(); rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rr_mode = 1'b0; preempt_en = '1; req = '0; seq_done = 1'b0;
    loop_done = 1'b0; prio_rd_sel = '0; load_unique();
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 act_valid", act_valid, 0);
    chk("R1 susp_valid", susp_valid, 0);
    chk("R3 unique cfg", cfg_err, 0);

    // R12 readback
    prio_rd_sel = 4'd4;  #1 chk("R12 ch4", prio_rd, 15);
    prio_rd_sel = 4'd11; #1 chk("R12 ch11", prio_rd, 0);

    // R2 fixed-priority winner table
    for (int v = 0; v < 8; v++) begin
      req = FX_VECS[v][19:4];
      step();
      chk("R2 valid", act_valid, 1);
      chk("R2 winner", act_idx, FX_VECS[v][3:0]);
      req = '0;
      pulse_loop();
      chk("R11 release", act_valid, 0);
    end

    // R3/R4 duplicate priority blocks grants
    prio_cfg[1*PW +: PW] = 4'd3;
    #1 chk("R3 dup flag", cfg_err, 1);
    req = 16'h0002;
    step();
    chk("R4 no grant", act_valid, 0);
    load_unique();
    #1 chk("R3 cleared", cfg_err, 0);
    step();
    chk("R4 grant after fix", act_idx, 1);
    req = '0; pulse_loop();

    // R5 preemption at a sequence boundary
    req = 16'h0800; step();
    chk("R5 start ch11", act_idx, 11);
    req = 16'h2800; step();
    chk("R5 hold without seq_done", act_idx, 11);
    chk("R5 no susp yet", susp_valid, 0);
    pulse_seq();
    chk("R5 preemptor", act_idx, 13);
    chk("R5 susp_valid", susp_valid, 1);
    chk("R5 susp_idx", susp_idx, 11);

    // R9 preemptor not preemptible
    req = 16'h2810; pulse_seq();
    chk("R9 still ch13", act_idx, 13);
    chk("R9 susp kept", susp_idx, 11);

    // R7 restore on loop done
    req = 16'h0810; pulse_loop();
    chk("R7 restored", act_idx, 11);
    chk("R7 susp cleared", susp_valid, 0);

    // R8 restored channel keeps one sequence
    step();
    chk("R8 guarded", act_idx, 11);
    pulse_seq();
    chk("R8 re-preempted", act_idx, 4);
    chk("R8 susp_idx", susp_idx, 11);
    req = 16'h0800; pulse_loop();
    chk("R7 second restore", act_idx, 11);
    req = '0; pulse_loop();
    chk("R11 idle", act_valid, 0);
    step();
    chk("R11 stays idle", act_valid, 0);

    // R6 disabled preemption
    preempt_en[11] = 1'b0;
    req = 16'h0800; step();
    req = 16'h0810; pulse_seq();
    chk("R6 not preempted", act_idx, 11);
    chk("R6 no susp", susp_valid, 0);
    req = 16'h0010; pulse_loop();
    chk("R11 drop", act_valid, 0);
    step();
    chk("R11 next grant", act_idx, 4);
    req = '0; pulse_loop();
    preempt_en = '1;

    // R10 round robin
    rr_mode = 1'b1;
    do_reset();
    req = 16'h1024; step();
    chk("R10 first from 0", act_idx, 2);
    req = 16'h1034; pulse_seq();
    chk("R10 no preempt", act_idx, 2);
    chk("R10 no susp", susp_valid, 0);
    pulse_loop(); step();
    chk("R10 rotate 4", act_idx, 4);
    pulse_loop(); step();
    chk("R10 rotate 5", act_idx, 5);
    pulse_loop(); step();
    chk("R10 rotate 12", act_idx, 12);
    pulse_loop(); step();
    chk("R10 wrap 2", act_idx, 2);
    req = '0; pulse_loop();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule